// File: doc/BRIEF.md
# Indirect CSR Access Permission Guard

This block is a purely combinational screen that sits next to a processor's CSR file. Each cycle it looks at one access to an indirect register-select or register-window CSR, at machine, supervisor or virtual-supervisor level. It decides whether the access traps with an illegal-instruction exception or a virtual-instruction exception. When the access is allowed, it decides whether a supervisor access made from VS-mode must be steered onto the virtual-supervisor copies.

The decision combines several inputs: the current privilege mode, a 3-bit code for the targeted CSR class, bit 60 of the machine and hypervisor state-enable registers, and four flags from the CSR file. The flags report whether the select value in force is implemented at the level being accessed. Rules are applied in three tiers:

1. Privilege and machine state-enable faults.
2. Virtualization faults.
3. Select-implemented faults.

The tiers are applied in that order, so at most one exception flag is ever raised. A parameter can drop the third tier for cores that handle unimplemented select values elsewhere.

Top module: `csr_ind_guard`

## Requirements
- R1: Class codes are 1 machine select, 2 machine window, 3 supervisor select, 4 supervisor window, 5 virtual-supervisor select and 6 virtual-supervisor window. Codes 0 and 7 raise no flag of any kind.
- R2: A machine-class access (code 1 or 2) from any mode other than M (privilege code 3) raises illegal-instruction.
- R3: Privilege codes are 0 U, 1 HS, 3 M, 4 VU and 5 VS; codes 2, 6 and 7 are undefined and raise illegal-instruction for every valid class. A U-mode access to a supervisor or virtual-supervisor class also raises illegal-instruction.
- R4: When the machine enable bit is 0, any supervisor or virtual-supervisor class access from a mode other than M raises illegal-instruction. This takes precedence over every virtual-instruction rule.
- R5: An M-mode access never depends on either enable bit and never raises virtual-instruction.
- R6: With the machine enable bit at 1, a VS- or VU-mode access to a virtual-supervisor class raises virtual-instruction, whatever the hypervisor bit is.
- R7: With the machine enable bit at 1, a VU-mode access to a supervisor class raises virtual-instruction.
- R8: With the machine enable bit at 1 and the hypervisor bit at 0, a VS-mode supervisor class access raises virtual-instruction, whatever the select-implemented flags are.
- R9: A window access raises illegal-instruction when the select value it uses is not implemented at the level it reaches. The flag consulted depends on the window:
  - machine window: the machine flag;
  - supervisor window from M or HS: the supervisor flag;
  - virtual-supervisor window from M or HS: the VS-select-at-HS flag;
  - supervisor window from VS: the VS-select-at-HS flag.
- R10: A VS-mode supervisor window access whose select value is implemented at HS level but not at VS level raises virtual-instruction.
- R11: Illegal-instruction and virtual-instruction are never raised together.
- R12: The redirect output is 1 exactly when a VS-mode supervisor class access raises no exception.
- R13: Every other access with a valid class raises no flag, for example an HS-mode supervisor window access with the machine enable bit set and the supervisor select implemented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prv_i | input | 3 | Current privilege mode code |
| cls_i | input | 3 | Targeted CSR class code |
| mse60_i | input | 1 | Bit 60 of the machine state-enable register |
| hse60_i | input | 1 | Bit 60 of the hypervisor state-enable register |
| msel_impl_i | input | 1 | Machine select value is implemented |
| ssel_impl_i | input | 1 | Supervisor select value is implemented |
| vsel_hs_impl_i | input | 1 | Virtual-supervisor select value is implemented at HS level |
| vsel_vs_impl_i | input | 1 | Virtual-supervisor select value is implemented at VS level |
| illegal_o | output | 1 | Raise illegal-instruction exception |
| virtual_o | output | 1 | Raise virtual-instruction exception |
| redirect_o | output | 1 | Steer the supervisor access to the virtual-supervisor copy |

## Verification
The guard is driven through every combination of privilege code, class code, the two enable bits and the four select-implemented flags. This sweep shows that each tier masks the lower ones:
- machine-bit illegal faults stay illegal even in VS or VU mode;
- the hypervisor-bit fault ignores the select flags;
- the select checks only matter once both earlier tiers pass.

Directed patterns then single out M-mode with both enable bits cleared, which separates ignoring the bits from honouring them. They also single out the VS-mode window case that is implemented at HS level only, which separates the virtual fault from the illegal one. Undefined privilege and class codes show that decoding gaps produce the specified fixed outcome.

// File: rtl/csr_ind_pkg.sv
package csr_ind_pkg;
   localparam int PRV_W = 3;
   localparam int CLS_W = 3;

   localparam logic [PRV_W-1:0] PRV_U  = 3'd0;
   localparam logic [PRV_W-1:0] PRV_HS = 3'd1;
   localparam logic [PRV_W-1:0] PRV_M  = 3'd3;
   localparam logic [PRV_W-1:0] PRV_VU = 3'd4;
   localparam logic [PRV_W-1:0] PRV_VS = 3'd5;

   localparam logic [CLS_W-1:0] CLS_MSEL  = 3'd1;
   localparam logic [CLS_W-1:0] CLS_MWIN  = 3'd2;
   localparam logic [CLS_W-1:0] CLS_SSEL  = 3'd3;
   localparam logic [CLS_W-1:0] CLS_SWIN  = 3'd4;
   localparam logic [CLS_W-1:0] CLS_VSSEL = 3'd5;
   localparam logic [CLS_W-1:0] CLS_VSWIN = 3'd6;

   typedef struct packed {
      logic valid;
      logic cls_m;
      logic cls_s;
      logic cls_vs;
      logic win;
      logic md_m;
      logic md_u;
      logic md_vu;
      logic md_vs;
      logic md_bad;
   } acc_dec_t;
endpackage

// File: rtl/csr_ind_decode.sv
module csr_ind_decode
   import csr_ind_pkg::*;
(
   input  logic [PRV_W-1:0] prv_i,
   input  logic [CLS_W-1:0] cls_i,
   output acc_dec_t         dec_o
);
   always_comb begin
      dec_o        = '0;
      dec_o.cls_m  = (cls_i == CLS_MSEL)  || (cls_i == CLS_MWIN);
      dec_o.cls_s  = (cls_i == CLS_SSEL)  || (cls_i == CLS_SWIN);
      dec_o.cls_vs = (cls_i == CLS_VSSEL) || (cls_i == CLS_VSWIN);
      dec_o.win    = (cls_i == CLS_MWIN) || (cls_i == CLS_SWIN) || (cls_i == CLS_VSWIN);
      dec_o.valid  = dec_o.cls_m || dec_o.cls_s || dec_o.cls_vs;
      dec_o.md_m   = (prv_i == PRV_M);
      dec_o.md_u   = (prv_i == PRV_U);
      dec_o.md_vu  = (prv_i == PRV_VU);
      dec_o.md_vs  = (prv_i == PRV_VS);
      dec_o.md_bad = !(dec_o.md_m || dec_o.md_u || dec_o.md_vu || dec_o.md_vs
                       || (prv_i == PRV_HS));
   end

   always_comb begin
      assert_dec_onehot_R3: assert ($onehot({dec_o.md_m, dec_o.md_u, dec_o.md_vu,
                                             dec_o.md_vs, dec_o.md_bad,
                                             prv_i == PRV_HS}))
         else $error("privilege decode not one-hot");
   end
endmodule

// File: rtl/csr_ind_gate.sv
module csr_ind_gate
   import csr_ind_pkg::*;
(
   input  acc_dec_t dec_i,
   input  logic     mse60_i,
   input  logic     hse60_i,
   output logic     priv_ill_o,
   output logic     virt_o
);
   logic sup_cls;
   logic virt_md;

   always_comb begin
      sup_cls = dec_i.cls_s || dec_i.cls_vs;
      virt_md = dec_i.md_vs || dec_i.md_vu;

      priv_ill_o = (dec_i.valid && dec_i.md_bad)
                || (dec_i.cls_m && !dec_i.md_m)
                || (dec_i.md_u && sup_cls)
                || (!dec_i.md_m && !mse60_i && sup_cls);

      virt_o = virt_md && mse60_i &&
               (dec_i.cls_vs
                || (dec_i.cls_s && dec_i.md_vu)
                || (dec_i.cls_s && dec_i.md_vs && !hse60_i));
   end

   always_comb begin
      assert_m_unaffected_R5: assert (!(dec_i.md_m && (priv_ill_o || virt_o)))
         else $error("M-mode access trapped at gate tier");
      assert_vs_cls_virt_R6: assert (!(virt_md && mse60_i && dec_i.cls_vs) || virt_o)
         else $error("VS/VU direct access to virtual-supervisor class not flagged");
      assert_gate_no_win_dep_R8: assert (!(dec_i.win && !dec_i.valid) )
         else $error("window flag set on invalid class");
   end
endmodule

// File: rtl/csr_ind_selchk.sv
module csr_ind_selchk #(
   parameter bit ENABLE = 1'b1
) (
   input  logic win_i,
   input  logic cls_m_i,
   input  logic cls_s_i,
   input  logic cls_vs_i,
   input  logic md_vs_i,
   input  logic msel_impl_i,
   input  logic ssel_impl_i,
   input  logic vsel_hs_impl_i,
   input  logic vsel_vs_impl_i,
   output logic sel_ill_o,
   output logic sel_virt_o
);
   generate
      if (ENABLE) begin : g_check
         logic s_via_vs;
         always_comb begin
            s_via_vs  = win_i && cls_s_i && md_vs_i;
            sel_ill_o = win_i && ((cls_m_i && !msel_impl_i)
                               || (cls_s_i && !md_vs_i && !ssel_impl_i)
                               || (cls_vs_i && !vsel_hs_impl_i)
                               || (s_via_vs && !vsel_hs_impl_i));
            sel_virt_o = s_via_vs && vsel_hs_impl_i && !vsel_vs_impl_i;
         end
         always_comb begin
            assert_sel_excl_R10: assert (!(sel_ill_o && sel_virt_o))
               else $error("select tier raised both kinds");
         end
      end else begin : g_bypass
         logic unused_in;
         assign unused_in = ^{win_i, cls_m_i, cls_s_i, cls_vs_i, md_vs_i, msel_impl_i,
                              ssel_impl_i, vsel_hs_impl_i, vsel_vs_impl_i};
         assign sel_ill_o  = 1'b0;
         assign sel_virt_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/csr_ind_guard.sv
module csr_ind_guard
   import csr_ind_pkg::*;
#(
   parameter int SEL_CHECK = 1
) (
   input  logic [2:0] prv_i,
   input  logic [2:0] cls_i,
   input  logic       mse60_i,
   input  logic       hse60_i,
   input  logic       msel_impl_i,
   input  logic       ssel_impl_i,
   input  logic       vsel_hs_impl_i,
   input  logic       vsel_vs_impl_i,
   output logic       illegal_o,
   output logic       virtual_o,
   output logic       redirect_o
);
   localparam bit SEL_EN = (SEL_CHECK != 0);

   generate
      if (SEL_CHECK < 0 || SEL_CHECK > 1) begin : g_bad_param
         $error("SEL_CHECK must be 0 or 1");
      end
      if (PRV_W != 3 || CLS_W != 3) begin : g_bad_width
         $error("port widths assume 3-bit codes");
      end
   endgenerate

   acc_dec_t dec;
   logic     t1_ill;
   logic     t2_virt;
   logic     t3_ill;
   logic     t3_virt;

   csr_ind_decode u_dec (
      .prv_i (prv_i),
      .cls_i (cls_i),
      .dec_o (dec)
   );

   csr_ind_gate u_gate (
      .dec_i      (dec),
      .mse60_i    (mse60_i),
      .hse60_i    (hse60_i),
      .priv_ill_o (t1_ill),
      .virt_o     (t2_virt)
   );

   csr_ind_selchk #(.ENABLE(SEL_EN)) u_sel (
      .win_i          (dec.win),
      .cls_m_i        (dec.cls_m),
      .cls_s_i        (dec.cls_s),
      .cls_vs_i       (dec.cls_vs),
      .md_vs_i        (dec.md_vs),
      .msel_impl_i    (msel_impl_i),
      .ssel_impl_i    (ssel_impl_i),
      .vsel_hs_impl_i (vsel_hs_impl_i),
      .vsel_vs_impl_i (vsel_vs_impl_i),
      .sel_ill_o      (t3_ill),
      .sel_virt_o     (t3_virt)
   );

   always_comb begin
      illegal_o  = t1_ill || (!t2_virt && t3_ill);
      virtual_o  = !t1_ill && (t2_virt || t3_virt);
      redirect_o = dec.md_vs && dec.cls_s && !illegal_o && !virtual_o;
   end

   always_comb begin
      assert_one_flag_R11: assert (!(illegal_o && virtual_o))
         else $error("both exception kinds raised");
      assert_redirect_clean_R12: assert (!redirect_o || (prv_i == PRV_VS && !illegal_o && !virtual_o))
         else $error("redirect with fault or outside VS-mode");
      assert_quiet_invalid_R1: assert (dec.valid || !(illegal_o || virtual_o || redirect_o))
         else $error("flag raised for unused class code");
      assert_m_no_virt_R5: assert (!(dec.md_m && virtual_o))
         else $error("virtual-instruction in M-mode");
      assert_mse_precedence_R4: assert (!(!dec.md_m && !mse60_i && (dec.cls_s || dec.cls_vs)) || illegal_o)
         else $error("machine enable fault not illegal");
   end
endmodule

// File: tb/csr_ind_guard_bench.sv
`timescale 1ns/1ps
module csr_ind_guard_bench;
   logic       clk = 1'b0;
   logic [2:0] prv, cls;
   logic       mse, hse, im, is, ivh, ivv;
   logic       ill, vir, red;
   int         checks = 0;
   int         fails  = 0;
   int         cycles = 0;
   bit         done   = 0;

   always #2.5 clk = ~clk;

   csr_ind_guard u_csr_ind_guard (
      .prv_i (prv), .cls_i (cls), .mse60_i (mse), .hse60_i (hse),
      .msel_impl_i (im), .ssel_impl_i (is), .vsel_hs_impl_i (ivh),
      .vsel_vs_impl_i (ivv), .illegal_o (ill), .virtual_o (vir), .redirect_o (red)
   );

   // behavioural reference built from the requirement list
   task automatic model(input int p, input int c, input bit me, input bit he,
                        input bit fm, input bit fs, input bit fvh, input bit fvv,
                        output logic [2:0] exp, output string tag);
      bit mcls = (c == 1 || c == 2);
      bit scls = (c == 3 || c == 4);
      bit vcls = (c == 5 || c == 6);
      bit okp  = (p == 0 || p == 1 || p == 3 || p == 4 || p == 5);
      exp = 3'b000;   // {illegal, virtual, redirect}
      if (!(mcls || scls || vcls))          begin tag = "R1"; end
      else if (!okp)                        begin exp = 3'b100; tag = "R3"; end
      else if (mcls && p != 3)              begin exp = 3'b100; tag = "R2"; end
      else if (p == 0)                      begin exp = 3'b100; tag = "R3"; end
      else if (p != 3 && !me)               begin exp = 3'b100; tag = "R4"; end
      else if ((p == 4 || p == 5) && vcls)  begin exp = 3'b010; tag = "R6"; end
      else if (p == 4 && scls)              begin exp = 3'b010; tag = "R7"; end
      else if (p == 5 && scls && !he)       begin exp = 3'b010; tag = "R8"; end
      else if (c == 2 && !fm)               begin exp = 3'b100; tag = "R9"; end
      else if (c == 4 && p != 5 && !fs)     begin exp = 3'b100; tag = "R9"; end
      else if (c == 6 && !fvh)              begin exp = 3'b100; tag = "R9"; end
      else if (c == 4 && p == 5 && !fvh)    begin exp = 3'b100; tag = "R9"; end
      else if (c == 4 && p == 5 && !fvv)    begin exp = 3'b010; tag = "R10"; end
      else if (p == 5 && scls)              begin exp = 3'b001; tag = "R12"; end
      else if (p == 3)                      begin tag = "R5"; end
      else                                  begin tag = "R13"; end
   endtask

   task automatic apply_and_check(input int p, input int c, input int f, input string note);
      logic [2:0] exp;
      string      tag;
      @(posedge clk);
      #1;
      prv = p[2:0]; cls = c[2:0];
      {mse, hse, im, is, ivh, ivv} = f[5:0];
      model(p, c, f[5], f[4], f[3], f[2], f[1], f[0], exp, tag);
      @(negedge clk);
      checks++;
      if ({ill, vir, red} !== exp) begin
         fails++;
         $display("FAIL %s %s prv=%0d cls=%0d f=%b actual=%b expected=%b",
                  tag, note, p, c, f[5:0], {ill, vir, red}, exp);
      end
      checks++;
      if (ill && vir) begin
         fails++;
         $display("FAIL R11 prv=%0d cls=%0d actual=%b expected=one flag at most",
                  p, c, {ill, vir});
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         fails++;
         $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      prv = '0; cls = '0; {mse, hse, im, is, ivh, ivv} = '0;
      // idle state: unused class code 0 gives no flags (R1)
      apply_and_check(0, 0, 0, "idle");
      // directed cases
      apply_and_check(3, 4, 6'b001111, "R5 M-mode with both enable bits clear");
      apply_and_check(3, 6, 6'b000011, "R5 M-mode vs window");
      apply_and_check(1, 2, 6'b111111, "R2 HS to machine window");
      apply_and_check(6, 3, 6'b111111, "R3 undefined privilege");
      apply_and_check(0, 5, 6'b111111, "R3 U to vs select");
      apply_and_check(5, 5, 6'b011111, "R4 beats R6 in VS");
      apply_and_check(4, 6, 6'b101111, "R6 VU to vs window");
      apply_and_check(4, 3, 6'b111111, "R7 VU to s select");
      apply_and_check(5, 4, 6'b100000, "R8 ignores select flags");
      apply_and_check(1, 4, 6'b111011, "R9 HS s window unimplemented");
      apply_and_check(5, 4, 6'b110001, "R9 VS s window not at HS");
      apply_and_check(5, 4, 6'b110010, "R10 HS-only select");
      apply_and_check(5, 4, 6'b110011, "R12 redirect");
      apply_and_check(5, 3, 6'b110000, "R12 redirect select");
      apply_and_check(1, 4, 6'b101111, "R13 grant");
      apply_and_check(7, 7, 6'b111111, "R1 code 7");
      // exhaustive sweep, tagged by the rule the model applied
      for (int p = 0; p < 8; p++)
         for (int c = 0; c < 8; c++)
            for (int f = 0; f < 64; f++)
               apply_and_check(p, c, f, "sweep");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule